// File: doc/BRIEF.md
# Serial Bus Wakeup Interrupt Controller

This block manages the low-power behaviour of a single-wire serial bus receiver. The host presents its power mode (run, wait or stop) and the raw bus receive line. A configuration bit decides whether host wait also parks the interface. While parked, the interface clock enable is dropped. A filtered falling edge on the bus then brings the interface back and raises a wakeup interrupt that no enable bit can mask.

The wakeup is reported through a small register window. There is a control register, a status register holding the interrupt flag, and an interrupt-source vector in which the wakeup outranks every other source. A frame that was in flight when the interface was parked is reported as corrupted. After a wakeup from host stop, the receiver is held closed until the bus has been idle for a set number of bit times. Only then are new frames accepted.

Top module: `lin_wake_unit`

## Requirements
- R1: After reset, ifClkEn is 1, intOut is 0, the control register reads 0 and the vector (address 2) reads 0.
- R2: When hostMode changes to stop (2), or to wait (1) while control bit 0 (wait-park) is 1, ifClkEn goes to 0 and stays 0 until the interface wakes or the host returns to run.
- R3: With control bit 0 cleared, host wait leaves ifClkEn at 1, and bus activity raises no interrupt.
- R4: While parked, a low level on rxLine lasting at least FILT_LEN synchronised cycles sets ifClkEn to 1 and raises intOut. A shorter low pulse has no effect.
- R5: The wakeup interrupt drives intOut even when control bit 1 (source enable) is 0.
- R6: The vector (address 2) reads 1 while a wakeup is pending, whatever else is pending. Otherwise it reads i+2 for the lowest-indexed srcReq[i], counted only when control bit 1 is 1, and 0 when nothing is pending. The status register (address 1) bit 0 is the interrupt flag.
- R7: A pending wakeup is cleared only by a status write with bit 0 set that follows a vector read made while the wakeup was pending. The status write alone leaves intOut high.
- R8: After a wakeup from host wait, a frame completed by the decoder is delivered on rxGood.
- R9: After a wakeup from host stop, frames completed before rxLine has stayed high for BIT_CYCLES*IDLE_BITS cycles give neither rxGood nor rxBad. Later frames give rxGood.
- R10: A frame that is active (frameActive) when the interface is parked completes on rxBad and not on rxGood.
- R11: Control bits 7..2 are reserved. Writes to them are ignored and they read 0.
- R12: If the host returns to run while the interface is parked and the bus is quiet, ifClkEn returns to 1 and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system and wakeup clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostMode | input | 2 | Host power mode: 0 run, 1 wait, 2 stop, 3 treated as run |
| rxLine | input | 1 | Raw bus receive line, idle high |
| frameActive | input | 1 | Frame decoder is in the middle of a frame |
| frameDone | input | 1 | One-cycle pulse from the frame decoder at frame end |
| srcReq | input | NSRC | Other interrupt source requests |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 control, 1 status, 2 vector |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Register read data, combinational |
| ifClkEn | output | 1 | Clock enable for the interface |
| intOut | output | 1 | Interrupt level, high while the flag is set |
| rxGood | output | 1 | Frame completed and accepted |
| rxBad | output | 1 | Frame completed but corrupted by a mode change |

## Verification
The bench checks that a wakeup pending alongside enabled sources still encodes as 1. A design that ranked sources the wrong way would report a source code instead. It writes the flag without a prior vector read and expects intOut to stay high, which catches a design that clears on the write alone. It sends a one-cycle glitch while the interface is parked, which a design with a short filter would take as a wakeup. It sends frames during and after the idle resynchronisation window following a stop wakeup, and completes a frame that was active at park time. A design that got these wrong would deliver a frame that must be dropped, or deliver a corrupted frame as good.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2,
    MODE_RSVD = 2'd3
  } hostMode_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_RESYNC = 2'd2
  } linState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setWake;
    logic markCorrupt;
    logic idleRun;
    logic rxOpen;
    logic ifClkOn;
  } ctlStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_VEC  = 2'd2;

endpackage

// File: rtl/lin_wake_fsm.sv
module lin_wake_fsm
  import lin_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] hostMode,
  input  logic       wcm,
  input  logic       frameActive,
  input  logic       fallEdge,
  input  logic       idleDone,
  output ctlStrobe_t ctl
);

  linState_e state, stateNext;
  logic stopReq, reqQ, fromStop, enterNow;

  always_comb begin
    stopReq = (hostMode == MODE_STOP) || ((hostMode == MODE_WAIT) && wcm);
  end

  always_comb begin
    enterNow = (state == ST_RUN) && stopReq && !reqQ;
  end

  always_comb begin
    stateNext = state;
    ctl = '0;
    case (state)
      ST_RUN: begin
        ctl.ifClkOn = 1'b1;
        ctl.rxOpen  = 1'b1;
        if (enterNow) begin
          stateNext       = ST_SLEEP;
          ctl.markCorrupt = frameActive;
        end
      end
      ST_SLEEP: begin
        if (fallEdge) begin
          ctl.setWake = 1'b1;
          stateNext   = fromStop ? ST_RESYNC : ST_RUN;
        end else if (!stopReq) begin
          stateNext = ST_RUN;
        end
      end
      ST_RESYNC: begin
        ctl.ifClkOn = 1'b1;
        ctl.idleRun = 1'b1;
        if (idleDone) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      reqQ     <= 1'b0;
      fromStop <= 1'b0;
    end else begin
      state <= stateNext;
      reqQ  <= stopReq;
      if (enterNow) fromStop <= (hostMode == MODE_STOP);
    end
  end

  // R2: a new park request in run removes the interface clock next cycle
  a_r2_park_gates: assert property (@(posedge clk) disable iff (!rstN)
    enterNow |=> !ctl.ifClkOn);

  // R3: host wait without the park bit keeps the interface clocked
  a_r3_wait_clocked: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && hostMode == MODE_WAIT && !wcm) |=> ctl.ifClkOn);

  // R12: leaving park on a quiet bus never raises a wakeup
  a_r12_quiet_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !stopReq && !fallEdge) |=> (state == ST_RUN));

endmodule

// File: rtl/lin_wake_dp.sv
module lin_wake_dp
  import lin_wake_pkg::*;
#(
  parameter int NSRC       = 4,
  parameter int REG_W      = 8,
  parameter int FILT_LEN   = 3,
  parameter int BIT_CYCLES = 4,
  parameter int IDLE_BITS  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             frameDone,
  input  logic [NSRC-1:0]  srcReq,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  ctlStrobe_t       ctl,
  output logic [REG_W-1:0] regRdData,
  output logic             wcm,
  output logic             fallEdge,
  output logic             idleDone,
  output logic             intOut,
  output logic             rxGood,
  output logic             rxBad
);

  localparam int IDLE_CYCLES = BIT_CYCLES * IDLE_BITS;
  localparam int IDLE_W      = $clog2(IDLE_CYCLES + 1);
  localparam int FILT_W      = $clog2(FILT_LEN + 1);

  logic syncA, rxSync, filtLine, filtQ;
  logic [FILT_W-1:0] lowCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic ien, wakePend, armed, corrupt;
  logic [REG_W-1:0] vecCode;
  logic srcAny, clearHit;
  logic unusedBits;

  assign unusedBits = ^{regWrData[REG_W-1:2], ctl.ifClkOn};

  // two-flop synchroniser and low-glitch filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      rxSync   <= 1'b1;
      lowCnt   <= '0;
      filtLine <= 1'b1;
      filtQ    <= 1'b1;
    end else begin
      syncA  <= rxLine;
      rxSync <= syncA;
      filtQ  <= filtLine;
      if (rxSync) begin
        lowCnt   <= '0;
        filtLine <= 1'b1;
      end else if (lowCnt == FILT_W'(FILT_LEN - 1)) begin
        filtLine <= 1'b0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  assign fallEdge = filtQ & ~filtLine;

  // idle-period counter for resynchronisation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (!ctl.idleRun || !rxSync) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_W'(IDLE_CYCLES)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign idleDone = (idleCnt == IDLE_W'(IDLE_CYCLES));

  // interrupt vector: wakeup first, then lowest-indexed enabled source
  always_comb begin
    vecCode = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (srcReq[i] && ien) vecCode = REG_W'(i + 2);
    end
    if (wakePend) vecCode = REG_W'(1);
  end

  assign srcAny   = |(srcReq & {NSRC{ien}});
  assign intOut   = wakePend | srcAny;
  assign clearHit = regWrEn && (regAddr == ADDR_STAT) && regWrData[0] && armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wcm      <= 1'b0;
      ien      <= 1'b0;
      wakePend <= 1'b0;
      armed    <= 1'b0;
      corrupt  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) begin
        wcm <= regWrData[0];
        ien <= regWrData[1];
      end
      if (ctl.setWake) begin
        wakePend <= 1'b1;
      end else if (clearHit) begin
        wakePend <= 1'b0;
        armed    <= 1'b0;
      end
      if (regRdEn && regAddr == ADDR_VEC && wakePend) armed <= 1'b1;
      if (ctl.markCorrupt)  corrupt <= 1'b1;
      else if (frameDone)   corrupt <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: regRdData[1:0] = {ien, wcm};
      ADDR_STAT: regRdData[0]   = intOut;
      ADDR_VEC:  regRdData      = vecCode;
      default:   regRdData      = '0;
    endcase
  end

  assign rxGood = frameDone & ctl.rxOpen & ~corrupt;
  assign rxBad  = frameDone & ctl.rxOpen & corrupt;

  // R4: a wakeup strobe leaves the interrupt raised
  a_r4_wake_raises: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setWake |=> intOut);

  // R7: without a prior vector read the wakeup survives any write
  a_r7_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (wakePend && !armed) |=> wakePend);

  // R9: a closed receiver delivers nothing
  a_r9_closed_silent: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rxOpen |-> !(rxGood || rxBad));

  // R10: a frame cut by a park is never reported good
  a_r10_cut_not_good: assert property (@(posedge clk) disable iff (!rstN)
    ctl.markCorrupt |=> !rxGood);

  // R5: wakeup keeps the interrupt high regardless of the enable bit
  a_r5_unmasked: assert property (@(posedge clk) disable iff (!rstN)
    (wakePend && !ien) |-> intOut);

endmodule

// File: rtl/lin_wake_unit.sv
module lin_wake_unit
  import lin_wake_pkg::*;
#(
  parameter int NSRC       = 4,
  parameter int REG_W      = 8,
  parameter int FILT_LEN   = 3,
  parameter int BIT_CYCLES = 4,
  parameter int IDLE_BITS  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       hostMode,
  input  logic             rxLine,
  input  logic             frameActive,
  input  logic             frameDone,
  input  logic [NSRC-1:0]  srcReq,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             ifClkEn,
  output logic             intOut,
  output logic             rxGood,
  output logic             rxBad
);

  ctlStrobe_t ctl;
  logic wcm, fallEdge, idleDone;

  lin_wake_fsm fsm_i (
    .clk        (clk),
    .rstN       (rstN),
    .hostMode   (hostMode),
    .wcm        (wcm),
    .frameActive(frameActive),
    .fallEdge   (fallEdge),
    .idleDone   (idleDone),
    .ctl        (ctl)
  );

  lin_wake_dp #(
    .NSRC      (NSRC),
    .REG_W     (REG_W),
    .FILT_LEN  (FILT_LEN),
    .BIT_CYCLES(BIT_CYCLES),
    .IDLE_BITS (IDLE_BITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .frameDone(frameDone),
    .srcReq   (srcReq),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .ctl      (ctl),
    .regRdData(regRdData),
    .wcm      (wcm),
    .fallEdge (fallEdge),
    .idleDone (idleDone),
    .intOut   (intOut),
    .rxGood   (rxGood),
    .rxBad    (rxBad)
  );

  assign ifClkEn = ctl.ifClkOn;

endmodule

// File: tb/lin_wake_unit_tb_top.sv
module lin_wake_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostMode = 2'd0;
  logic       rxLine = 1'b1;
  logic       frameActive = 1'b0;
  logic       frameDone = 1'b0;
  logic [3:0] srcReq = 4'd0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       ifClkEn, intOut, rxGood, rxBad;

  int nChecks = 0;
  int nFail   = 0;
  int goodCnt = 0;
  int badCnt  = 0;

  always #2 clk = ~clk;

  lin_wake_unit dut_i (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .rxLine(rxLine),
    .frameActive(frameActive), .frameDone(frameDone), .srcReq(srcReq),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ifClkEn(ifClkEn),
    .intOut(intOut), .rxGood(rxGood), .rxBad(rxBad)
  );

  always @(posedge clk) begin
    if (rxGood) goodCnt++;
    if (rxBad)  badCnt++;
  end

  // {srcReq[3:0], enable, expected vector[7:0], expected interrupt}
  localparam logic [13:0] VEC_TBL [6] = '{
    {4'b0000, 1'b1, 8'd0, 1'b0},
    {4'b0001, 1'b1, 8'd2, 1'b1},
    {4'b0100, 1'b1, 8'd4, 1'b1},
    {4'b1010, 1'b1, 8'd3, 1'b1},
    {4'b1000, 1'b1, 8'd5, 1'b1},
    {4'b1111, 1'b0, 8'd0, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    regRdEn = 1'b1;
    #1;
    d = regRdData;
    step(1);
    regRdEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    step(1);
    regWrEn = 1'b0;
  endtask

  task automatic busLow(input int n);
    rxLine = 1'b0;
    step(n);
    rxLine = 1'b1;
  endtask

  task automatic pulseDone();
    frameDone = 1'b1;
    step(1);
    frameDone = 1'b0;
    step(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    int g0, b0;
    step(3);
    rstN = 1'b1;
    step(2);

    // R1 reset state
    check("R1 ifClkEn", ifClkEn, 1);
    check("R1 intOut", intOut, 0);
    regRead(2'd0, rd); check("R1 ctrl", rd, 0);
    regRead(2'd2, rd); check("R1 vector", rd, 0);

    // R6 vector table with no wakeup pending
    for (int k = 0; k < 6; k++) begin
      srcReq = VEC_TBL[k][13:10];
      regWrite(2'd0, {6'd0, VEC_TBL[k][9], 1'b0});
      regRead(2'd2, rd);
      check("R6 vector", rd, VEC_TBL[k][8:1]);
      check("R6 intOut", intOut, VEC_TBL[k][0]);
    end
    srcReq = 4'd0;

    // R11 reserved control bits
    regWrite(2'd0, 8'hFF);
    regRead(2'd0, rd); check("R11 reserved", rd, 8'h03);
    regWrite(2'd0, 8'h02);

    // R3 wait with park bit clear
    hostMode = 2'd1;
    step(3);
    check("R3 clocked in wait", ifClkEn, 1);
    busLow(8); step(4);
    check("R3 no interrupt", intOut, 0);
    hostMode = 2'd0; step(2);

    // R2 / R4 / R5 park on wait, enable cleared
    regWrite(2'd0, 8'h01);
    hostMode = 2'd1;
    step(3);
    check("R2 gated in wait", ifClkEn, 0);
    busLow(1); step(6);
    check("R4 glitch ignored clk", ifClkEn, 0);
    check("R4 glitch ignored int", intOut, 0);
    busLow(8); step(2);
    check("R4 woke clk", ifClkEn, 1);
    check("R5 unmasked int", intOut, 1);
    hostMode = 2'd0; step(2);

    // R8 frame after wakeup from wait
    g0 = goodCnt;
    pulseDone();
    check("R8 frame delivered", goodCnt, g0 + 1);

    // R7 flag write alone
    regWrite(2'd1, 8'h01);
    check("R7 write alone", intOut, 1);
    // R6 wakeup outranks enabled source
    regWrite(2'd0, 8'h03);
    srcReq = 4'b0001;
    regRead(2'd2, rd); check("R6 wake top", rd, 1);
    srcReq = 4'd0;
    regWrite(2'd1, 8'h01);
    check("R7 cleared", intOut, 0);
    regRead(2'd2, rd); check("R7 vector zero", rd, 0);

    // R12 quiet exit from stop
    hostMode = 2'd2; step(3);
    check("R2 gated in stop", ifClkEn, 0);
    hostMode = 2'd0; step(3);
    check("R12 clock back", ifClkEn, 1);
    check("R12 no interrupt", intOut, 0);

    // R9 wakeup from stop with resynchronisation
    hostMode = 2'd2; step(3);
    g0 = goodCnt; b0 = badCnt;
    rxLine = 1'b0; step(8);
    check("R4 stop wake int", intOut, 1);
    pulseDone();
    hostMode = 2'd0;
    rxLine = 1'b1; step(5);
    pulseDone();
    check("R9 dropped good", goodCnt, g0);
    check("R9 dropped bad", badCnt, b0);
    step(20);
    pulseDone();
    check("R9 accepted later", goodCnt, g0 + 1);
    regRead(2'd2, rd);
    regWrite(2'd1, 8'h01);
    check("R7 cleared again", intOut, 0);

    // R10 frame cut by park
    g0 = goodCnt; b0 = badCnt;
    frameActive = 1'b1;
    hostMode = 2'd1; step(3);
    busLow(8); step(2);
    frameActive = 1'b0;
    hostMode = 2'd0; step(1);
    pulseDone();
    check("R10 bad count", badCnt, b0 + 1);
    check("R10 good count", goodCnt, g0);
    pulseDone();
    check("R10 next frame good", goodCnt, g0 + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule